// File: doc/BRIEF.md
# Prioritized Event Acceptance Controller

This block sits beside the fetch stage of a small processor core and picks which pending event the core accepts next. The candidates are a debug request, four critical events that no mask can block, a vector of synchronous exception requests, and four interrupt levels. The core feeds in the current status-register mask bits and a busy flag that it raises while it is saving context.

On acceptance the block pulses a valid strobe for one cycle. With that strobe it presents the event's identity, a mode code that encodes the event's priority, a register-bank select and the handler address for the program counter. It also presents a new mask vector in which every source at the same or lower priority is masked. The core writes that vector back into its status register, so further events of that rank are held off until software lowers the masks again.

Requests are level-sensitive. A source must hold its request until it sees its own acceptance. The block never stores a request.

Top module: `evt_accept_ctrl`

## Requirements
- R1: Mask vector layout: bits 0 to 3 mask interrupt levels 0 to 3, bit 4 masks exceptions, bit 5 is the global mask and bit 6 is the debug mask. Interrupt level k needs both bit k and bit 5 clear to be accepted. A synchronous exception needs bit 4 clear.
- R2: A critical request is accepted whatever the mask vector holds.
- R3: Priority from highest to lowest is debug, critical, synchronous exception, interrupt 3, 2, 1 and 0. Within the critical and exception vectors the lowest asserted index wins.
- R4: On acceptance, maskOut equals maskIn with these bits forced to one:
  - interrupt level k forces bits 0 to k;
  - an exception or a critical event forces bits 0 to 5;
  - debug forces bits 0 to 6.
- R5: The mode code is 1 to 4 for interrupt levels 0 to 3, 5 for a synchronous exception, 6 for a critical event and 7 for debug. bankSel is k+1 for interrupt level k and 0 for every other event.
- R6: Identity numbering is:
  - debug is 0;
  - critical index i is 1+i;
  - exception index j is 5+j;
  - interrupt level k is 5+NUM_EXC+(3-k).
  handlerPc is HANDLER_BASE + id*HANDLER_STRIDE, which by default is 0x100 + id*0x10.
- R7: A debug request is accepted only while mask bit 6 is clear.
- R8: The decision uses the request levels sampled at a clock edge. Its results appear in the cycle after that edge. A request that is dropped before it is accepted leaves no trace.
- R9: At most one event is accepted per edge. Nothing is accepted while stackBusy is high or while accValid is high, so a request that stays asserted is accepted again at the earliest two cycles later.
- R10: After reset, accValid, accId, modeOut, bankSel, maskOut and handlerPc are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| intReq | input | 4 | Interrupt level requests, bit k is level k |
| excReq | input | NUM_EXC | Synchronous exception requests |
| critReq | input | 4 | Unmaskable critical event requests |
| dbgReq | input | 1 | Debug entry request |
| maskIn | input | 7 | Current status-register mask bits |
| stackBusy | input | 1 | Core is saving context; hold off acceptance |
| accValid | output | 1 | One-cycle acceptance strobe |
| accId | output | ID_W | Identity of the accepted event |
| modeOut | output | 3 | Mode code carrying the accepted priority |
| bankSel | output | 3 | Register-bank select |
| maskOut | output | 7 | Status mask vector after acceptance |
| handlerPc | output | ADDR_W | Handler address for the program counter |

## Verification
Two things can happen in the same cycle: the arbitration picks a winner, and the hold-off from stackBusy or from a standing acceptance strobe blocks it. The bench provokes this by keeping requests asserted across an acceptance and across a busy window. It expects the strobe pattern accept, silence, accept in the first case, and only silence in the second. The bench also raises a critical event in the same cycle as masked interrupts and masked exceptions. It judges each expected item taken from its queue on identity, mode, bank, mask and handler address.

// File: rtl/evt_accept_pkg.sv
package evt_accept_pkg;

  localparam int NUM_INT  = 4;
  localparam int NUM_CRIT = 4;
  localparam int MASK_W   = 7;
  localparam int SLOT_W   = 8;

  // mask bit positions
  localparam int MB_EXC  = 4;
  localparam int MB_GLOB = 5;
  localparam int MB_DBG  = 6;

  typedef enum logic [2:0] {
    LVL_NONE = 3'd0,
    LVL_INT0 = 3'd1,
    LVL_INT1 = 3'd2,
    LVL_INT2 = 3'd3,
    LVL_INT3 = 3'd4,
    LVL_EXC  = 3'd5,
    LVL_CRIT = 3'd6,
    LVL_DBG  = 3'd7
  } evtLevel_e;

  typedef struct packed {
    logic              accept;
    evtLevel_e         level;
    logic [SLOT_W-1:0] slot;
  } ctrlStrobe_t;

endpackage

// File: rtl/evt_arb_ctrl.sv
module evt_arb_ctrl
  import evt_accept_pkg::*;
#(
  parameter int NUM_EXC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_INT-1:0]  intReq,
  input  logic [NUM_EXC-1:0]  excReq,
  input  logic [NUM_CRIT-1:0] critReq,
  input  logic                dbgReq,
  input  logic [MASK_W-1:0]   maskIn,
  input  logic                stackBusy,
  input  logic                accValid,
  output ctrlStrobe_t         strobe
);

  logic [NUM_INT-1:0] intOk;
  logic               dbgOk, critAny, excOk, holdOff;
  logic [SLOT_W-1:0]  critSlot, excSlot;
  logic [6:0]         grantVec;

  genvar g;
  generate
    for (g = 0; g < NUM_INT; g++) begin : gIntGate
      assign intOk[g] = intReq[g] & ~maskIn[g] & ~maskIn[MB_GLOB];
    end
  endgenerate

  assign dbgOk   = dbgReq & ~maskIn[MB_DBG];
  assign critAny = |critReq;
  assign excOk   = (|excReq) & ~maskIn[MB_EXC];
  assign holdOff = stackBusy | accValid;

  // lowest asserted index in each vector
  always_comb begin
    critSlot = '0;
    for (int i = NUM_CRIT - 1; i >= 0; i--) begin
      if (critReq[i]) critSlot = SLOT_W'(i);
    end
    excSlot = '0;
    for (int i = NUM_EXC - 1; i >= 0; i--) begin
      if (excReq[i]) excSlot = SLOT_W'(i);
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.level = LVL_NONE;
    grantVec     = '0;
    if (!holdOff) begin
      if (dbgOk) begin
        strobe.accept = 1'b1;
        strobe.level  = LVL_DBG;
        grantVec[6]   = 1'b1;
      end else if (critAny) begin
        strobe.accept = 1'b1;
        strobe.level  = LVL_CRIT;
        strobe.slot   = critSlot;
        grantVec[5]   = 1'b1;
      end else if (excOk) begin
        strobe.accept = 1'b1;
        strobe.level  = LVL_EXC;
        strobe.slot   = excSlot;
        grantVec[4]   = 1'b1;
      end else if (intOk[3]) begin
        strobe.accept = 1'b1;
        strobe.level  = LVL_INT3;
        grantVec[3]   = 1'b1;
      end else if (intOk[2]) begin
        strobe.accept = 1'b1;
        strobe.level  = LVL_INT2;
        grantVec[2]   = 1'b1;
      end else if (intOk[1]) begin
        strobe.accept = 1'b1;
        strobe.level  = LVL_INT1;
        grantVec[1]   = 1'b1;
      end else if (intOk[0]) begin
        strobe.accept = 1'b1;
        strobe.level  = LVL_INT0;
        grantVec[0]   = 1'b1;
      end
    end
  end

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  // R2
  crit_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (critAny && !dbgReq && !stackBusy && !accValid) |-> strobe.level == LVL_CRIT);

endmodule

// File: rtl/evt_accept_dp.sv
module evt_accept_dp
  import evt_accept_pkg::*;
#(
  parameter int          NUM_EXC        = 4,
  parameter int          ADDR_W         = 32,
  parameter logic [31:0] HANDLER_BASE   = 32'h0000_0100,
  parameter logic [31:0] HANDLER_STRIDE = 32'h0000_0010,
  localparam int         NUM_ID         = 1 + NUM_CRIT + NUM_EXC + NUM_INT,
  localparam int         ID_W           = $clog2(NUM_ID)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [MASK_W-1:0] maskIn,
  input  logic              stackBusy,
  output logic              accValid,
  output logic [ID_W-1:0]   accId,
  output logic [2:0]        modeOut,
  output logic [2:0]        bankSel,
  output logic [MASK_W-1:0] maskOut,
  output logic [ADDR_W-1:0] handlerPc
);

  localparam int CRIT_BASE = 1;
  localparam int EXC_BASE  = CRIT_BASE + NUM_CRIT;
  localparam int INT_BASE  = EXC_BASE + NUM_EXC;

  logic [ADDR_W-1:0] handlerTab [NUM_ID];
  logic [ID_W-1:0]   idNext;
  logic [MASK_W-1:0] raiseBits;
  logic [2:0]        bankNext;
  int                intLvl;

  genvar g;
  generate
    for (g = 0; g < NUM_ID; g++) begin : gHandler
      assign handlerTab[g] = ADDR_W'(HANDLER_BASE + HANDLER_STRIDE * 32'(g));
    end
  endgenerate

  always_comb begin
    intLvl    = int'(strobe.level) - 1;
    idNext    = '0;
    raiseBits = '0;
    bankNext  = '0;
    unique case (strobe.level)
      LVL_DBG: begin
        idNext    = '0;
        raiseBits = '1;
      end
      LVL_CRIT: begin
        idNext    = ID_W'(CRIT_BASE + int'(strobe.slot));
        raiseBits = MASK_W'((1 << (MB_GLOB + 1)) - 1);
      end
      LVL_EXC: begin
        idNext    = ID_W'(EXC_BASE + int'(strobe.slot));
        raiseBits = MASK_W'((1 << (MB_GLOB + 1)) - 1);
      end
      LVL_INT0, LVL_INT1, LVL_INT2, LVL_INT3: begin
        idNext    = ID_W'(INT_BASE + (NUM_INT - 1) - intLvl);
        raiseBits = MASK_W'((1 << (intLvl + 1)) - 1);
        bankNext  = 3'(intLvl + 1);
      end
      default: begin
        idNext    = '0;
        raiseBits = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accValid  <= 1'b0;
      accId     <= '0;
      modeOut   <= '0;
      bankSel   <= '0;
      maskOut   <= '0;
      handlerPc <= '0;
    end else begin
      accValid <= strobe.accept;
      if (strobe.accept) begin
        accId     <= idNext;
        modeOut   <= strobe.level;
        bankSel   <= bankNext;
        maskOut   <= maskIn | raiseBits;
        handlerPc <= handlerTab[idNext];
      end
    end
  end

  // R9
  one_per_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> !accValid);

  // R9
  busy_respect_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> !$past(stackBusy));

  // R1
  int0_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && modeOut == 3'(LVL_INT0)) |-> (!$past(maskIn[0]) && !$past(maskIn[MB_GLOB])));

  // R4
  low_raised_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> maskOut[0]);

  // R4
  exc_masks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && modeOut >= 3'(LVL_EXC)) |-> (maskOut[MB_EXC] && maskOut[MB_GLOB]));

  // R7
  dbg_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && modeOut == 3'(LVL_DBG)) |-> (maskOut[MB_DBG] && !$past(maskIn[MB_DBG])));

endmodule

// File: rtl/evt_accept_ctrl.sv
module evt_accept_ctrl
  import evt_accept_pkg::*;
#(
  parameter int          NUM_EXC        = 4,
  parameter int          ADDR_W         = 32,
  parameter logic [31:0] HANDLER_BASE   = 32'h0000_0100,
  parameter logic [31:0] HANDLER_STRIDE = 32'h0000_0010,
  localparam int         ID_W           = $clog2(1 + NUM_CRIT + NUM_EXC + NUM_INT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_INT-1:0]  intReq,
  input  logic [NUM_EXC-1:0]  excReq,
  input  logic [NUM_CRIT-1:0] critReq,
  input  logic                dbgReq,
  input  logic [MASK_W-1:0]   maskIn,
  input  logic                stackBusy,
  output logic                accValid,
  output logic [ID_W-1:0]     accId,
  output logic [2:0]          modeOut,
  output logic [2:0]          bankSel,
  output logic [MASK_W-1:0]   maskOut,
  output logic [ADDR_W-1:0]   handlerPc
);

  ctrlStrobe_t strobe;

  evt_arb_ctrl #(.NUM_EXC(NUM_EXC)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .intReq    (intReq),
    .excReq    (excReq),
    .critReq   (critReq),
    .dbgReq    (dbgReq),
    .maskIn    (maskIn),
    .stackBusy (stackBusy),
    .accValid  (accValid),
    .strobe    (strobe)
  );

  evt_accept_dp #(
    .NUM_EXC        (NUM_EXC),
    .ADDR_W         (ADDR_W),
    .HANDLER_BASE   (HANDLER_BASE),
    .HANDLER_STRIDE (HANDLER_STRIDE)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .maskIn    (maskIn),
    .stackBusy (stackBusy),
    .accValid  (accValid),
    .accId     (accId),
    .modeOut   (modeOut),
    .bankSel   (bankSel),
    .maskOut   (maskOut),
    .handlerPc (handlerPc)
  );

endmodule

// File: tb/evt_accept_ctrl_tb.sv
module evt_accept_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NEXC       = 4;

  typedef struct {
    int         id;
    int         mode;
    int         bank;
    logic [6:0] mask;
    logic [31:0] pc;
    string      req;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [3:0]        intReq = '0;
  logic [NEXC-1:0]   excReq = '0;
  logic [3:0]        critReq = '0;
  logic              dbgReq = 1'b0;
  logic [6:0]        maskIn = '0;
  logic              stackBusy = 1'b0;
  logic              accValid;
  logic [3:0]        accId;
  logic [2:0]        modeOut, bankSel;
  logic [6:0]        maskOut;
  logic [31:0]       handlerPc;

  int       nChecks = 0;
  int       nBad = 0;
  bit       finished = 1'b0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_accept_ctrl #(.NUM_EXC(NEXC)) dut_i (
    .clk(clk), .rstN(rstN), .intReq(intReq), .excReq(excReq), .critReq(critReq),
    .dbgReq(dbgReq), .maskIn(maskIn), .stackBusy(stackBusy), .accValid(accValid),
    .accId(accId), .modeOut(modeOut), .bankSel(bankSel), .maskOut(maskOut),
    .handlerPc(handlerPc)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // expected item builders, from R4, R5, R6
  function automatic expItem_t mkInt(int k, logic [6:0] m, string req);
    expItem_t e;
    e.id = 5 + NEXC + (3 - k);
    e.mode = k + 1;
    e.bank = k + 1;
    e.mask = m | 7'((1 << (k + 1)) - 1);
    e.pc = 32'h100 + 32'(e.id) * 32'h10;
    e.req = req;
    return e;
  endfunction

  function automatic expItem_t mkExc(int j, logic [6:0] m, string req);
    expItem_t e;
    e.id = 5 + j;
    e.mode = 5;
    e.bank = 0;
    e.mask = m | 7'h3F;
    e.pc = 32'h100 + 32'(e.id) * 32'h10;
    e.req = req;
    return e;
  endfunction

  function automatic expItem_t mkCrit(int i, logic [6:0] m, string req);
    expItem_t e;
    e.id = 1 + i;
    e.mode = 6;
    e.bank = 0;
    e.mask = m | 7'h3F;
    e.pc = 32'h100 + 32'(e.id) * 32'h10;
    e.req = req;
    return e;
  endfunction

  function automatic expItem_t mkDbg(string req);
    expItem_t e;
    e.id = 0;
    e.mode = 7;
    e.bank = 0;
    e.mask = 7'h7F;
    e.pc = 32'h100;
    e.req = req;
    return e;
  endfunction

  // monitor: pops and compares on every strobe
  always @(negedge clk) begin
    if (rstN && accValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "unexpected acceptance id", longint'(accId), -1);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(int'(accId) == e.id, e.req, "accId", longint'(accId), longint'(e.id));
        check(int'(modeOut) == e.mode && int'(bankSel) == e.bank, e.req, "mode/bank",
              longint'({modeOut, bankSel}), longint'({3'(e.mode), 3'(e.bank)}));
        check(maskOut == e.mask, e.req, "maskOut", longint'(maskOut), longint'(e.mask));
        check(handlerPc == e.pc, e.req, "handlerPc", longint'(handlerPc), longint'(e.pc));
      end
    end
  end

  // driver: one request pattern for one decision edge
  task automatic trial(input logic [3:0] ir, input logic [NEXC-1:0] er,
                       input logic [3:0] cr, input logic dr, input logic [6:0] m,
                       input bit expAcc, input expItem_t e);
    @(posedge clk); #1;
    intReq = ir; excReq = er; critReq = cr; dbgReq = dr; maskIn = m;
    if (expAcc) expQ.push_back(e);
    @(posedge clk); #1;
    intReq = '0; excReq = '0; critReq = '0; dbgReq = 1'b0;
    @(negedge clk);
    if (!expAcc) check(accValid == 1'b0, e.req, "no acceptance", longint'(accValid), 0);
    @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin : main
    expItem_t none;
    none.req = "";
    #1;
    @(negedge clk);
    // R10 reset state
    check(accValid == 0 && accId == 0 && modeOut == 0 && bankSel == 0 &&
          maskOut == 0 && handlerPc == 0, "R10", "reset outputs",
          longint'({accValid, accId, modeOut, bankSel, maskOut}), 0);
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 R5 R6: INT1 alone
    trial(4'b0010, '0, '0, 0, 7'h00, 1, mkInt(1, 7'h00, "R5"));
    // R1: INT1 held by its own mask, then by the global mask
    none.req = "R1"; trial(4'b0010, '0, '0, 0, 7'h02, 0, none);
    none.req = "R1"; trial(4'b0010, '0, '0, 0, 7'h20, 0, none);
    // R1 R3: INT3 masked, INT0 taken
    trial(4'b1001, '0, '0, 0, 7'h08, 1, mkInt(0, 7'h08, "R1"));
    // R3: lowest exception index wins; R6 identity
    trial(4'b0000, 4'b1010, '0, 0, 7'h00, 1, mkExc(1, 7'h00, "R3"));
    // R1: exception masked, INT2 passes
    trial(4'b0100, 4'b0001, '0, 0, 7'h10, 1, mkInt(2, 7'h10, "R1"));
    // R2: critical with every mask set
    trial(4'b1111, 4'b1111, 4'b0100, 0, 7'h3F, 1, mkCrit(2, 7'h3F, "R2"));
    trial('0, '0, 4'b0001, 0, 7'h7F, 1, mkCrit(0, 7'h7F, "R2"));
    // R3: critical tie, critical above exception and INT3
    trial('0, '0, 4'b1010, 0, 7'h00, 1, mkCrit(1, 7'h00, "R3"));
    trial(4'b1000, 4'b0100, 4'b1000, 0, 7'h00, 1, mkCrit(3, 7'h00, "R3"));
    // R7: debug blocked by its mask, then debug over everything
    none.req = "R7"; trial('0, '0, '0, 1, 7'h40, 0, none);
    trial(4'b1111, 4'b0001, 4'b0001, 1, 7'h00, 1, mkDbg("R7"));

    // R4: accepted masks fed back hold off lower levels
    trial(4'b0101, '0, '0, 0, 7'h00, 1, mkInt(2, 7'h00, "R4"));
    none.req = "R4"; trial(4'b0001, '0, '0, 0, 7'h07, 0, none);
    trial(4'b1001, '0, '0, 0, 7'h07, 1, mkInt(3, 7'h07, "R4"));

    // R9: stackBusy holds off a standing request
    @(posedge clk); #1;
    maskIn = 7'h00; stackBusy = 1'b1; intReq = 4'b0010;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(accValid == 1'b0, "R9", "busy hold-off", longint'(accValid), 0);
    end
    @(posedge clk); #1;
    expQ.push_back(mkInt(1, 7'h00, "R9"));
    stackBusy = 1'b0;
    @(posedge clk); #1;
    intReq = '0;
    @(posedge clk);

    // R9: standing request accepted, gap, accepted again
    @(posedge clk); #1;
    intReq = 4'b1000;
    expQ.push_back(mkInt(3, 7'h00, "R9"));
    expQ.push_back(mkInt(3, 7'h00, "R9"));
    @(posedge clk);
    @(negedge clk);
    check(accValid == 1'b1, "R9", "first strobe", longint'(accValid), 1);
    @(negedge clk);
    check(accValid == 1'b0, "R9", "gap after strobe", longint'(accValid), 0);
    @(posedge clk); #1;
    intReq = '0;
    @(posedge clk);

    // R8: request dropped during busy leaves no trace
    @(posedge clk); #1;
    stackBusy = 1'b1; excReq = 4'b0100;
    @(posedge clk); #1;
    excReq = '0;
    @(posedge clk); #1;
    stackBusy = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(accValid == 1'b0, "R8", "dropped request", longint'(accValid), 0);
    end

    repeat (3) @(posedge clk);
    check(expQ.size() == 0, "R9", "missing acceptances", longint'(expQ.size()), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule